// File: doc/BRIEF.md
# Compressed Paired Load/Store Expander

This decode-stage unit serves a 32-bit RISC-V core that supports paired doubleword memory accesses. Each cycle it receives one 16-bit compressed instruction word. If the word is one of the four compressed paired forms, it produces the equivalent full-width 32-bit instruction. The four forms are:

- load relative to the stack pointer;
- store relative to the stack pointer;
- load relative to a compact base register;
- store relative to a compact base register.

Three configuration inputs report which extensions are enabled. The core's register width is a parameter. These paired forms reuse encoding slots that would otherwise hold compressed single-precision float loads and stores. For that reason the unit only claims a word when the float-compressed option is off. In every other case it leaves the word to other decoders.

The result is registered through one pipeline stage and comes out with a valid bit one cycle after the input. A match flag means the word was recognised. An illegal flag means the word was recognised but names a register that cannot hold a pair.

Top module: `cpair_expand`

## Requirements
- R1: A word is matched only when all of the following hold: `XLEN` is 32, `en_pair` is 1, `en_comp` is 1, `en_fcomp` is 0, and `in_valid` is 1. Otherwise `out_match` and `out_illegal` are 0 and `out_insn` is 0.
- R2: Stack-pointer load: bits[1:0]=10 and bits[15:13]=011.
  - Offset: bit12 is uimm[5], bits[6:5] are uimm[4:3], bits[4:2] are uimm[8:6].
  - Destination: bits[11:7].
  - Expansion: opcode 0000011, funct3 011, base x2, offset in I-type bits[31:20].
- R3: Stack-pointer store: bits[1:0]=10 and bits[15:13]=111.
  - Offset: bits[12:10] are uimm[5:3], bits[9:7] are uimm[8:6].
  - Data source: bits[6:2].
  - Expansion: opcode 0100011, funct3 011, base x2, offset split across S-type bits[31:25] and [11:7].
- R4: Register load: bits[1:0]=00 and bits[15:13]=011.
  - Offset: bits[12:10] are uimm[5:3], bits[6:5] are uimm[7:6].
  - Base: compact field bits[9:7]. Destination: compact field bits[4:2].
  - Expansion: I-type load with funct3 011.
- R5: Register store: bits[1:0]=00 and bits[15:13]=111.
  - Offset and base are laid out as in R4. Data source: compact field bits[4:2].
  - Expansion: S-type store with funct3 011.
- R6: A 3-bit compact register field c selects register 8+c, i.e. the 5-bit index {01,c}.
- R7: Every offset has uimm[2:0]=0 and is zero-extended to 12 bits. The stack-pointer forms reach at most 504. The register forms reach at most 248.
- R8: A stack-pointer load whose destination is x0 raises `out_illegal`.
- R9: Any form whose load destination or store source is an odd register raises `out_illegal`. Store source x0 is legal.
- R10: `out_illegal` is only ever 1 together with `out_match`. While `out_illegal` is 1, `out_insn` is 0.
- R11: Any word outside the four (quadrant, funct3) pairs of R2 to R5 gives `out_match`=0 and `out_illegal`=0.
- R12: All outputs are registered. `out_valid` repeats `in_valid` one cycle later. Each output reflects the input of the previous cycle. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_insn | input | 16 | Compressed instruction word |
| en_pair | input | 1 | Paired doubleword load/store extension enabled |
| en_comp | input | 1 | Base compressed extension enabled |
| en_fcomp | input | 1 | Compressed single-precision float extension enabled |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_insn | output | 32 | Expanded instruction, zero when not a legal match |
| out_match | output | 1 | Input was one of the four paired forms |
| out_illegal | output | 1 | Matched form names an unusable register |

## Verification
The unit has only one register stage, so any wrong decode appears in the very next cycle. A faulty field extraction or slot classification shows up as a wrong bit in `out_insn` or a wrong flag on the cycle after the word was presented. It cannot be hidden by later state.

The bench sweeps every 16-bit word against an independent bit-shuffle model with the extensions enabled. This means:
- a single mis-wired offset bit is reported on the first word that sets that bit;
- a mis-routed register bit is reported the same way;
- a missing parity test on the register is reported on the first odd register.

Further directed cases cover each gating input, the 64-bit parameter variant, dropped valid, and reset.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  localparam int CW   = 16;
  localparam int IW   = 32;
  localparam int RW   = 5;
  localparam int CRW  = 3;
  localparam int OFFW = 12;

  typedef enum logic [2:0] {
    FM_NONE = 3'd0,
    FM_SPLD = 3'd1,
    FM_SPST = 3'd2,
    FM_RGLD = 3'd3,
    FM_RGST = 3'd4
  } form_e;

  localparam logic [6:0]    OPC_LOAD  = 7'b0000011;
  localparam logic [6:0]    OPC_STORE = 7'b0100011;
  localparam logic [2:0]    F3_DW     = 3'b011;
  localparam logic [RW-1:0] REG_SP    = 5'd2;

  // compact register index to full index (x8..x15)
  function automatic logic [RW-1:0] creg(input logic [CRW-1:0] c);
    return {2'b01, c};
  endfunction

  // stack-pointer load offset, doubleword scaled
  function automatic logic [OFFW-1:0] off_spld(input logic [CW-1:0] w);
    return {3'b000, w[4:2], w[12], w[6:5], 3'b000};
  endfunction

  // stack-pointer store offset, doubleword scaled
  function automatic logic [OFFW-1:0] off_spst(input logic [CW-1:0] w);
    return {3'b000, w[9:7], w[12:10], 3'b000};
  endfunction

  // register-relative offset, doubleword scaled
  function automatic logic [OFFW-1:0] off_rg(input logic [CW-1:0] w);
    return {4'b0000, w[6:5], w[12:10], 3'b000};
  endfunction

  function automatic logic [IW-1:0] mk_itype(input logic [OFFW-1:0] imm,
                                             input logic [RW-1:0] base,
                                             input logic [RW-1:0] dst);
    return {imm, base, F3_DW, dst, OPC_LOAD};
  endfunction

  function automatic logic [IW-1:0] mk_stype(input logic [OFFW-1:0] imm,
                                             input logic [RW-1:0] src,
                                             input logic [RW-1:0] base);
    return {imm[11:5], src, base, F3_DW, imm[4:0], OPC_STORE};
  endfunction
endpackage

// File: rtl/cpx_decode.sv
module cpx_decode
  import cpx_pkg::*;
(
  input  logic [CW-1:0]   word,
  output form_e           form,
  output logic [OFFW-1:0] off,
  output logic [RW-1:0]   base,
  output logic [RW-1:0]   dst,
  output logic [RW-1:0]   src
);
  logic [1:0] quad;
  logic [2:0] f3;

  assign quad = word[1:0];
  assign f3   = word[15:13];

  always_comb begin
    form = FM_NONE;
    if (quad == 2'b10 && f3 == 3'b011) form = FM_SPLD;
    else if (quad == 2'b10 && f3 == 3'b111) form = FM_SPST;
    else if (quad == 2'b00 && f3 == 3'b011) form = FM_RGLD;
    else if (quad == 2'b00 && f3 == 3'b111) form = FM_RGST;
  end

  always_comb begin
    off  = '0;
    base = '0;
    dst  = '0;
    src  = '0;
    case (form)
      FM_SPLD: begin
        off  = off_spld(word);
        base = REG_SP;
        dst  = word[11:7];
      end
      FM_SPST: begin
        off  = off_spst(word);
        base = REG_SP;
        src  = word[6:2];
      end
      FM_RGLD: begin
        off  = off_rg(word);
        base = creg(word[9:7]);
        dst  = creg(word[4:2]);
      end
      FM_RGST: begin
        off  = off_rg(word);
        base = creg(word[9:7]);
        src  = creg(word[4:2]);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cpx_build.sv
module cpx_build
  import cpx_pkg::*;
(
  input  form_e           form,
  input  logic [OFFW-1:0] off,
  input  logic [RW-1:0]   base,
  input  logic [RW-1:0]   dst,
  input  logic [RW-1:0]   src,
  output logic [IW-1:0]   insn,
  output logic            bad_reg
);
  logic is_load;
  logic is_store;

  assign is_load  = (form == FM_SPLD) || (form == FM_RGLD);
  assign is_store = (form == FM_SPST) || (form == FM_RGST);

  always_comb begin
    bad_reg = 1'b0;
    if (is_load)  bad_reg = dst[0];
    if (is_store) bad_reg = src[0];
    if (form == FM_SPLD && dst == '0) bad_reg = 1'b1;
  end

  always_comb begin
    insn = '0;
    if (is_load)       insn = mk_itype(off, base, dst);
    else if (is_store) insn = mk_stype(off, src, base);
  end
endmodule

// File: rtl/cpair_expand.sv
module cpair_expand
  import cpx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [15:0]   in_insn,
  input  logic          en_pair,
  input  logic          en_comp,
  input  logic          en_fcomp,
  output logic          out_valid,
  output logic [31:0]   out_insn,
  output logic          out_match,
  output logic          out_illegal
);
  logic            xlen_ok;
  logic            ext_ok;
  form_e           form;
  logic [OFFW-1:0] off;
  logic [RW-1:0]   base;
  logic [RW-1:0]   dst;
  logic [RW-1:0]   src;
  logic [IW-1:0]   built;
  logic            bad_reg;
  logic            hit_next;
  logic            ill_next;
  logic [IW-1:0]   insn_next;

  generate
    if (XLEN == 32) begin : g_x32
      assign xlen_ok = 1'b1;
    end else begin : g_xother
      assign xlen_ok = 1'b0;
    end
  endgenerate

  assign ext_ok = xlen_ok & en_pair & en_comp & ~en_fcomp;

  cpx_decode u_dec (
    .word (in_insn),
    .form (form),
    .off  (off),
    .base (base),
    .dst  (dst),
    .src  (src)
  );

  cpx_build u_bld (
    .form    (form),
    .off     (off),
    .base    (base),
    .dst     (dst),
    .src     (src),
    .insn    (built),
    .bad_reg (bad_reg)
  );

  assign hit_next  = in_valid & ext_ok & (form != FM_NONE);
  assign ill_next  = hit_next & bad_reg;
  assign insn_next = (hit_next & ~bad_reg) ? built : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_match   <= 1'b0;
      out_illegal <= 1'b0;
      out_insn    <= '0;
    end else begin
      out_valid   <= in_valid;
      out_match   <= hit_next;
      out_illegal <= ill_next;
      out_insn    <= insn_next;
    end
  end
endmodule

// File: rtl/cpair_expand_chk.sv
module cpair_expand_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        ext_ok,
  input logic        hit_next,
  input logic        out_valid,
  input logic [31:0] out_insn,
  input logic        out_match,
  input logic        out_illegal
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R12
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R12
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_ok |=> (!out_match && !out_illegal));  // R1
  AST_HIT_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
    hit_next |=> out_match);  // R11
  AST_ILL_IMPLIES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_match);  // R10
  AST_ILL_ZERO_INSN: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_insn == 32'd0));  // R10
  AST_MATCH_FUNCT3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_match && !out_illegal) |-> (out_insn[14:12] == 3'b011));  // R2
  AST_MATCH_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_match && !out_illegal) |->
      (out_insn[6:0] == 7'b0000011 || out_insn[6:0] == 7'b0100011));  // R3
endmodule

bind cpair_expand cpair_expand_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .ext_ok      (ext_ok),
  .hit_next    (hit_next),
  .out_valid   (out_valid),
  .out_insn    (out_insn),
  .out_match   (out_match),
  .out_illegal (out_illegal)
);

// File: tb/tb_cpair_expand.sv
module tb_cpair_expand;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_insn = '0;
  logic        en_pair = 1'b1;
  logic        en_comp = 1'b1;
  logic        en_fcomp = 1'b0;
  logic        out_valid, out_match, out_illegal;
  logic [31:0] out_insn;
  logic        v64_valid, v64_match, v64_illegal;
  logic [31:0] v64_insn;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cpair_expand #(.XLEN(32)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .en_pair(en_pair), .en_comp(en_comp), .en_fcomp(en_fcomp),
    .out_valid(out_valid), .out_insn(out_insn),
    .out_match(out_match), .out_illegal(out_illegal));

  cpair_expand #(.XLEN(64)) dut64 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
    .en_pair(en_pair), .en_comp(en_comp), .en_fcomp(en_fcomp),
    .out_valid(v64_valid), .out_insn(v64_insn),
    .out_match(v64_match), .out_illegal(v64_illegal));

  // reference: returns {match, illegal, insn}
  function automatic logic [33:0] ref_model(input logic [15:0] c, input bit ok);
    logic [8:0]  u;
    logic [4:0]  rd, rs, rb;
    logic [11:0] im;
    logic        m, il, ld;
    logic [31:0] x;
    u = '0; rd = '0; rs = '0; rb = '0; m = 1'b0; il = 1'b0; ld = 1'b0; x = '0;
    if (c[1:0] == 2'b10 && c[15:13] == 3'b011) begin
      m = 1'b1; ld = 1'b1; rb = 5'd2; rd = c[11:7];
      u[5] = c[12]; u[4] = c[6]; u[3] = c[5]; u[8] = c[4]; u[7] = c[3]; u[6] = c[2];
      il = (rd == 5'd0) || rd[0];
    end else if (c[1:0] == 2'b10 && c[15:13] == 3'b111) begin
      m = 1'b1; rb = 5'd2; rs = c[6:2];
      u[5] = c[12]; u[4] = c[11]; u[3] = c[10]; u[8] = c[9]; u[7] = c[8]; u[6] = c[7];
      il = rs[0];
    end else if (c[1:0] == 2'b00 && (c[15:13] == 3'b011 || c[15:13] == 3'b111)) begin
      m = 1'b1; ld = !c[15];
      rb = 5'd8 + {2'b00, c[9:7]};
      u[5] = c[12]; u[4] = c[11]; u[3] = c[10]; u[7] = c[6]; u[6] = c[5];
      if (ld) rd = 5'd8 + {2'b00, c[4:2]};
      else    rs = 5'd8 + {2'b00, c[4:2]};
      il = c[2];
    end
    im = {3'b000, u};
    if (ld) x = {im, rb, 3'b011, rd, 7'h03};
    else    x = {im[11:5], rs, rb, 3'b011, im[4:0], 7'h23};
    if (!ok || !m) return 34'd0;
    if (il) return {2'b11, 32'd0};
    return {2'b10, x};
  endfunction

  task automatic chk(input string req, input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s insn=%h act=%h exp=%h", req, in_insn, act, exp);
    end
  endtask

  // drive at negedge, sample just after the next posedge
  task automatic apply(input logic [15:0] w, input bit v, input string req, input bit ok);
    @(negedge clk);
    in_insn = w;
    in_valid = v;
    @(posedge clk);
    #1;
    chk(req, {out_match, out_illegal, out_insn}, ref_model(w, ok && v));
    checks++;
    if (out_valid !== v) begin
      failures++;
      $display("FAIL R12 out_valid act=%b exp=%b", out_valid, v);
    end
  endtask

  task automatic t_reset;
    @(posedge clk); #1;
    chk("R12 reset", {out_match, out_illegal, out_insn}, 34'd0);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R12 reset out_valid act=%b exp=0", out_valid);
    end
  endtask

  task automatic t_directed;
    // R2 max offset 504, rd=x10: uimm 111111000
    apply({3'b011, 1'b1, 5'd10, 2'b11, 3'b111, 2'b10}, 1'b1, "R2 sp load max", 1'b1);
    chk("R7 sp load max imm", {2'b00, out_insn[31:20], 20'd0}, {2'b00, 12'd504, 20'd0});
    // R3 max offset 504, rs2=x0 legal
    apply({3'b111, 3'b111, 3'b111, 5'd0, 2'b10}, 1'b1, "R3 sp store x0 max", 1'b1);
    chk("R9 store x0 legal", {1'b0, out_illegal, 32'd0}, 34'd0);
    // R4 max offset 248, base x15 dst x14
    apply({3'b011, 3'b111, 3'b111, 2'b11, 3'b110, 2'b00}, 1'b1, "R4 rg load max", 1'b1);
    chk("R6 base x15", {29'd0, out_insn[19:15]}, {29'd0, 5'd15});
    chk("R7 rg load 248", {22'd0, out_insn[31:20]}, {22'd0, 12'd248});
    // R5 zero offset base x8 src x8
    apply({3'b111, 3'b000, 3'b000, 2'b00, 3'b000, 2'b00}, 1'b1, "R5 rg store zero", 1'b1);
    // R8 sp load rd x0
    apply({3'b011, 1'b0, 5'd0, 5'd0, 2'b10}, 1'b1, "R8 sp load x0", 1'b1);
    chk("R8 flag", {33'd0, out_illegal}, 34'd1);
    // R9 odd destination
    apply({3'b011, 3'b000, 3'b000, 2'b00, 3'b001, 2'b00}, 1'b1, "R9 rg load x9", 1'b1);
    chk("R9 flag", {33'd0, out_illegal}, 34'd1);
    // R11 quadrant 1 and wrong funct3
    apply({3'b011, 11'h2a5, 2'b01}, 1'b1, "R11 quadrant 1", 1'b1);
    apply({3'b010, 11'h0f0, 2'b10}, 1'b1, "R11 funct3 010", 1'b1);
    // R12 dropped valid
    apply({3'b011, 1'b0, 5'd4, 5'd0, 2'b10}, 1'b0, "R12 no valid", 1'b1);
  endtask

  task automatic t_gating;
    logic [15:0] w;
    w = {3'b011, 1'b1, 5'd6, 5'b01010, 2'b10};
    en_fcomp = 1'b1; apply(w, 1'b1, "R1 fcomp on", 1'b0); en_fcomp = 1'b0;
    en_pair  = 1'b0; apply(w, 1'b1, "R1 pair off", 1'b0); en_pair  = 1'b1;
    en_comp  = 1'b0; apply(w, 1'b1, "R1 comp off", 1'b0); en_comp  = 1'b1;
    apply(w, 1'b1, "R1 all on", 1'b1);
    chk("R1 xlen64", {v64_match, v64_illegal, v64_insn}, 34'd0);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 65536; i++) begin
      apply(i[15:0], 1'b1, "R2-sweep R3 R4 R5 R6 R7 R8 R9 R10 R11", 1'b1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_directed();
    t_gating();
    t_sweep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000 && !done) begin
      failures = failures + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule